// File: doc/BRIEF.md
# Drift-Compensating Stereo Sample FIFO

This block carries stereo audio frames between two clock domains that run from separate oscillators at nominally the same sample rate. A receiver that recovers frames from an incoming digital audio stream pushes them in on the write clock. A serial audio transmitter that is a clock master and cannot be slowed pulls them out on the read clock. Because the two rates never match exactly (the source can run about one frame per second fast at 48 kHz), the fill level drifts over time. The block keeps the fill level inside its limits without stalling either side.

Each entry holds a full left/right pair, so a correction never splits a stereo frame. When the write-side fill reaches a high watermark, incoming frames are discarded. When the read-side fill falls to a low watermark, requests repeat the last frame. Both guards use hysteresis. During silence, the write side steers the fill level back to the midpoint by discarding or doubling quiet frames, so that the corrections are made where they cannot be heard. Pointers cross the domains in Gray code, and each side computes its own fill level.

Input back-pressure rules: `in_ready` is high after reset and drops for exactly one write-clock cycle, which is the cycle after a quiet frame was accepted for doubling. A frame is taken on a rising `wr_clk` edge where `in_valid` and `in_ready` are both high. A taken frame may still be discarded by a guard. The output side has no back-pressure: every `frm_req` pulse is served on the next `rd_clk` edge.

Top module: `audio_drift_fifo`

## Requirements
- R1: After reset `in_ready` is 1, `out_left` and `out_right` are 0 and all three counters are 0.
- R2: Until the read-side fill first reaches MID_FILL (16), frame requests leave both outputs at 0 and count no repeat. From then on, a request updates the outputs on the next `rd_clk` edge.
- R3: Frames leave in arrival order. Left and right of one input frame always leave together, and no output frame exists that was never written.
- R4: When the write-side fill reaches HI_MARK (28), taken frames are discarded until the fill falls to HI_MARK-HYST (25). Each discard increments `drop_cnt`, and the fill never exceeds HI_MARK. This guard takes priority over silence handling.
- R5: When the read-side fill is at or below LO_MARK (4), requests repeat the last output frame and increment `rep_cnt` until the fill reaches LO_MARK+HYST (7). With no writes, the fill settles at exactly LO_MARK, and a frame is never read from an empty FIFO.
- R6: A frame is quiet when both channels, read as two's complement, have a magnitude of at most SIL_THR (16). Silence begins on the SIL_LEN-th (8th) consecutive quiet frame, and `recenter_cnt` increments once for each such episode. Any non-quiet frame ends the episode, and a run of SIL_LEN-1 quiet frames does not count.
- R7: While silence holds, a quiet frame is discarded if the write fill is above MID_FILL, written twice if it is below, and written once if it is equal. These discards do not touch `drop_cnt`.
- R8: A one-cycle pulse on `clr_drop` or `clr_recenter` (write clock) or on `clr_rep` (read clock) zeroes that counter on the next edge. The counters saturate at their maximum.
- R9: `in_ready` falls only in the cycle after a doubled write and stays low for exactly one cycle. It stays high throughout non-silent traffic, including while the overflow guard discards frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock (recovered input rate) |
| wr_rst_n | input | 1 | Write-side active-low reset |
| in_valid | input | 1 | Input frame present |
| in_ready | output | 1 | Input frame can be taken |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| clr_drop | input | 1 | Clear pulse for drop_cnt |
| clr_recenter | input | 1 | Clear pulse for recenter_cnt |
| drop_cnt | output | 16 | Frames discarded by the overflow guard |
| recenter_cnt | output | 16 | Silence episodes that re-centred the fill |
| rd_clk | input | 1 | Read-side clock (local transmitter rate) |
| rd_rst_n | input | 1 | Read-side active-low reset |
| frm_req | input | 1 | Frame request pulse from the transmitter |
| out_left | output | 24 | Left sample of the current output frame |
| out_right | output | 24 | Right sample of the current output frame |
| clr_rep | input | 1 | Clear pulse for rep_cnt |
| rep_cnt | output | 16 | Requests served by repeating a frame |

## Verification
Two functions can act in the same write cycle: the silence re-centring and the overflow guard. Both want to discard a frame, and only the guard may count it. A second coincidence is a doubled write, which forces `in_ready` low in the very cycle after a frame is taken. The bench drains the FIFO to exactly the low watermark, then feeds a scripted silent passage in which frames are doubled, written once and discarded. It judges the result by the exact order of the twenty frames that follow, by the count of `in_ready` low cycles, and by `drop_cnt` staying at zero. In the random phases, where the guard does discard, the sum of the gaps in the output sequence must equal `drop_cnt`.

// File: rtl/adf_pkg.sv
`timescale 1ns/1ps
package adf_pkg;
  parameter int unsigned SAMPLE_W = 24;

  typedef struct packed {
    logic [SAMPLE_W-1:0] l;
    logic [SAMPLE_W-1:0] r;
  } frame_t;
endpackage

// File: rtl/adf_ptr_sync.sv
`timescale 1ns/1ps
// Carries a Gray-coded pointer into another clock domain and returns it as binary.
module adf_ptr_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], gray_in};
  end

  always_comb begin
    bin_out[W-1] = stg[STAGES-1][W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ stg[STAGES-1][i];
  end
endmodule

// File: rtl/adf_wr_ctrl.sv
`timescale 1ns/1ps
// Write domain: overflow guard, silence detection and re-centring, write pointer.
module adf_wr_ctrl import adf_pkg::*; #(
  parameter int unsigned AW       = 5,
  parameter int unsigned MID_FILL = 16,
  parameter int unsigned HI_MARK  = 28,
  parameter int unsigned HYST     = 3,
  parameter int unsigned SIL_THR  = 16,
  parameter int unsigned SIL_LEN  = 8,
  parameter int unsigned CW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  frame_t        in_frame,
  input  logic [AW:0]   rptr_bin,
  input  logic          clr_drop,
  input  logic          clr_recenter,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output frame_t        wr_frame,
  output logic [AW:0]   wptr_gray,
  output logic [AW:0]   wfill,
  output logic [CW-1:0] drop_cnt,
  output logic [CW-1:0] recenter_cnt
);
  localparam int unsigned PW = AW + 1;
  localparam int unsigned RW = $clog2(SIL_LEN + 1);

  logic [PW-1:0] wptr_q, wnext;
  logic          drop_q, dup_q;
  frame_t        held_q;
  logic [RW-1:0] run_q;
  logic          accept, quiet, silent, sil_mode, drop_now, sil_discard, dbl;

  function automatic logic is_small(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] m;
    m = s[SAMPLE_W-1] ? (~s + SAMPLE_W'(1)) : s;
    return m <= SAMPLE_W'(SIL_THR);
  endfunction

  assign wfill    = wptr_q - rptr_bin;
  assign in_ready = !dup_q;
  assign accept   = in_valid && in_ready;
  assign quiet    = is_small(in_frame.l) && is_small(in_frame.r);
  assign silent   = (run_q == RW'(SIL_LEN));
  assign sil_mode = silent && quiet;
  assign drop_now = drop_q ? (wfill > PW'(HI_MARK - HYST)) : (wfill >= PW'(HI_MARK));
  assign sil_discard = sil_mode && (wfill > PW'(MID_FILL));
  assign wr_en    = dup_q || (accept && !drop_now && !sil_discard);
  assign dbl      = accept && !drop_now && sil_mode && (wfill < PW'(MID_FILL));
  assign wr_frame = dup_q ? held_q : in_frame;
  assign wr_addr  = wptr_q[AW-1:0];
  assign wnext    = wptr_q + {{AW{1'b0}}, wr_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      wptr_gray <= '0;
      drop_q    <= 1'b0;
      dup_q     <= 1'b0;
      held_q    <= '0;
    end else begin
      wptr_q    <= wnext;
      wptr_gray <= wnext ^ (wnext >> 1);
      drop_q    <= drop_now;
      dup_q     <= dbl;
      if (accept) held_q <= in_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (accept) begin
      if (!quiet)       run_q <= '0;
      else if (!silent) run_q <= run_q + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_cnt     <= '0;
      recenter_cnt <= '0;
    end else begin
      if (clr_drop) drop_cnt <= '0;
      else if (accept && drop_now && drop_cnt != '1) drop_cnt <= drop_cnt + CW'(1);
      if (clr_recenter) recenter_cnt <= '0;
      else if (accept && quiet && run_q == RW'(SIL_LEN - 1) && recenter_cnt != '1)
        recenter_cnt <= recenter_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/adf_rd_ctrl.sv
`timescale 1ns/1ps
// Read domain: priming, underflow guard with frame repeat, read pointer.
module adf_rd_ctrl import adf_pkg::*; #(
  parameter int unsigned AW       = 5,
  parameter int unsigned MID_FILL = 16,
  parameter int unsigned LO_MARK  = 4,
  parameter int unsigned HYST     = 3,
  parameter int unsigned CW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_req,
  input  logic [AW:0]   wptr_bin,
  input  frame_t        rd_frame,
  input  logic          clr_rep,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   rptr_gray,
  output logic [AW:0]   rfill,
  output logic          primed,
  output logic          rd_pop,
  output frame_t        out_frame,
  output logic [CW-1:0] rep_cnt
);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] rptr_q, rnext;
  logic          rep_q, rep_now, rep_hit;

  assign rfill   = wptr_bin - rptr_q;
  assign rep_now = rep_q ? (rfill < PW'(LO_MARK + HYST)) : (rfill <= PW'(LO_MARK));
  assign rd_pop  = frm_req && primed && !rep_now;
  assign rep_hit = frm_req && primed && rep_now;
  assign rd_addr = rptr_q[AW-1:0];
  assign rnext   = rptr_q + {{AW{1'b0}}, rd_pop};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q    <= '0;
      rptr_gray <= '0;
      rep_q     <= 1'b0;
      primed    <= 1'b0;
      out_frame <= '0;
      rep_cnt   <= '0;
    end else begin
      rptr_q    <= rnext;
      rptr_gray <= rnext ^ (rnext >> 1);
      rep_q     <= rep_now;
      if (rfill >= PW'(MID_FILL)) primed <= 1'b1;
      if (rd_pop) out_frame <= rd_frame;
      if (clr_rep) rep_cnt <= '0;
      else if (rep_hit && rep_cnt != '1) rep_cnt <= rep_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/audio_drift_fifo.sv
`timescale 1ns/1ps
module audio_drift_fifo import adf_pkg::*; #(
  parameter int unsigned AW          = 5,
  parameter int unsigned MID_FILL    = 16,
  parameter int unsigned HI_MARK     = 28,
  parameter int unsigned LO_MARK     = 4,
  parameter int unsigned HYST        = 3,
  parameter int unsigned SIL_THR     = 16,
  parameter int unsigned SIL_LEN     = 8,
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                wr_clk,
  input  logic                wr_rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                clr_drop,
  input  logic                clr_recenter,
  output logic [CW-1:0]       drop_cnt,
  output logic [CW-1:0]       recenter_cnt,
  input  logic                rd_clk,
  input  logic                rd_rst_n,
  input  logic                frm_req,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  input  logic                clr_rep,
  output logic [CW-1:0]       rep_cnt
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  frame_t        mem [DEPTH];
  frame_t        in_frame, wr_frame, rd_frame, out_frame;
  logic          wr_en, rd_pop, primed;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wptr_gray, rptr_gray, wptr_rsync, rptr_wsync, wfill, rfill;

  assign in_frame  = {in_left, in_right};
  assign out_left  = out_frame.l;
  assign out_right = out_frame.r;

  adf_wr_ctrl #(
    .AW(AW), .MID_FILL(MID_FILL), .HI_MARK(HI_MARK), .HYST(HYST),
    .SIL_THR(SIL_THR), .SIL_LEN(SIL_LEN), .CW(CW)
  ) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_frame(in_frame), .rptr_bin(rptr_wsync), .clr_drop(clr_drop),
    .clr_recenter(clr_recenter), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_frame(wr_frame), .wptr_gray(wptr_gray), .wfill(wfill),
    .drop_cnt(drop_cnt), .recenter_cnt(recenter_cnt)
  );

  adf_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rptr_gray), .bin_out(rptr_wsync)
  );

  adf_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wptr_gray), .bin_out(wptr_rsync)
  );

  adf_rd_ctrl #(
    .AW(AW), .MID_FILL(MID_FILL), .LO_MARK(LO_MARK), .HYST(HYST), .CW(CW)
  ) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .frm_req(frm_req), .wptr_bin(wptr_rsync),
    .rd_frame(rd_frame), .clr_rep(clr_rep), .rd_addr(rd_addr),
    .rptr_gray(rptr_gray), .rfill(rfill), .primed(primed), .rd_pop(rd_pop),
    .out_frame(out_frame), .rep_cnt(rep_cnt)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_frame;
  end

  assign rd_frame = mem[rd_addr];
endmodule

// File: rtl/adf_chk.sv
`timescale 1ns/1ps
module adf_chk import adf_pkg::*; #(
  parameter int unsigned AW      = 5,
  parameter int unsigned HI_MARK = 28,
  parameter int unsigned CW      = 16
) (
  input logic                wr_clk,
  input logic                wr_rst_n,
  input logic                rd_clk,
  input logic                rd_rst_n,
  input logic                in_ready,
  input logic                frm_req,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic [CW-1:0]       drop_cnt,
  input logic [CW-1:0]       rep_cnt,
  input logic                clr_drop,
  input logic                clr_rep,
  input logic                wr_en,
  input logic                rd_pop,
  input logic                primed,
  input logic [AW:0]         wfill,
  input logic [AW:0]         rfill
);
  // R4
  fill_cap_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wfill <= (AW+1)'(HI_MARK));

  // R5
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_pop |-> rfill != '0);

  // R2
  silent_until_primed_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !primed |-> (out_left == '0 && out_right == '0));

  // R5
  repeat_holds_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (frm_req && primed && !rd_pop) |=> ($stable(out_left) && $stable(out_right)));

  // R8
  drop_clear_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    clr_drop |=> drop_cnt == '0);

  // R8
  rep_clear_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    clr_rep |=> rep_cnt == '0);

  // R9
  ready_gap_one_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !in_ready |=> in_ready);

  // R9
  ready_after_write_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $fell(in_ready) |-> $past(wr_en));
endmodule

bind audio_drift_fifo adf_chk #(.AW(AW), .HI_MARK(HI_MARK), .CW(CW)) u_chk (.*);

// File: tb/sim_audio_drift_fifo.sv
`timescale 1ns/1ps
module sim_audio_drift_fifo;
  logic        wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic        in_valid = 0, frm_req = 0;
  logic        clr_drop = 0, clr_recenter = 0, clr_rep = 0;
  logic [23:0] in_left = '0, in_right = '0;
  logic        in_ready;
  logic [23:0] out_left, out_right;
  logic [15:0] drop_cnt, recenter_cnt, rep_cnt;

  int  ntests = 0, nfail = 0;
  int  prev = 0, wtag = 0, sumgap = 0, low_cnt = 0;
  bit  wdone = 0, finished = 0;

  always #2   wr_clk = ~wr_clk;
  always #2.2 rd_clk = ~rd_clk;

  audio_drift_fifo u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .clr_drop(clr_drop),
    .clr_recenter(clr_recenter), .drop_cnt(drop_cnt), .recenter_cnt(recenter_cnt),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .frm_req(frm_req), .out_left(out_left),
    .out_right(out_right), .clr_rep(clr_rep), .rep_cnt(rep_cnt)
  );

  always @(negedge wr_clk) if (wr_rst_n && !in_ready) low_cnt++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] loud(input int tag);
    return 24'(tag + 1000);
  endfunction

  task automatic send(input logic [23:0] l, input logic [23:0] r);
    @(negedge wr_clk);
    in_valid = 1; in_left = l; in_right = r;
    @(negedge wr_clk);
    in_valid = 0;
  endtask

  task automatic send_loud();
    wtag++;
    send(loud(wtag), ~loud(wtag));
  endtask

  task automatic req_raw();
    @(negedge rd_clk); frm_req = 1;
    @(negedge rd_clk); frm_req = 0;
  endtask

  // Request one frame in a tagged stream and judge it (R3, R5)
  task automatic req_stream(input bit strict);
    int rb, tag;
    rb = rep_cnt;
    req_raw();
    chk(out_right == ~out_left, "R3 pair", out_right, ~out_left);
    tag = int'(out_left) - 1000;
    if (int'(rep_cnt) == rb + 1) begin
      chk(tag == prev, "R5 repeat", tag, prev);
    end else begin
      chk(int'(rep_cnt) == rb, "R5 count", rep_cnt, rb);
      if (strict) chk(tag == prev + 1, "R3 order", tag, prev + 1);
      else        chk(tag > prev, "R3 order", tag, prev + 1);
      if (tag > prev) sumgap += tag - prev - 1;
      prev = tag;
    end
  endtask

  task automatic stream_phase(input int nw, input int wlo, input int whi,
                              input int rgap, input bit strict);
    wdone = 0;
    fork
      begin
        for (int i = 0; i < nw; i++) begin
          repeat ($urandom_range(whi, wlo)) @(negedge wr_clk);
          send_loud();
        end
        wdone = 1;
      end
      begin
        while (!wdone) begin
          repeat (rgap) @(negedge rd_clk);
          req_stream(strict);
        end
      end
    join
  endtask

  initial begin
    #600us;
    if (!finished) begin
      nfail++; ntests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic [23:0] el [20];
    logic [23:0] er [20];
    int lc, k;
    void'($urandom(32'd7731));
    repeat (5) @(negedge wr_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge wr_clk);
    // R1 reset state
    chk(in_ready == 1, "R1 ready", in_ready, 1);
    chk(out_left == 0 && out_right == 0, "R1 out", out_left, 0);
    chk(drop_cnt == 0 && rep_cnt == 0 && recenter_cnt == 0, "R1 counters",
        drop_cnt + rep_cnt + recenter_cnt, 0);

    // R2 priming
    for (int i = 0; i < 10; i++) begin send_loud(); @(negedge wr_clk); end
    repeat (20) @(negedge rd_clk);
    for (int i = 0; i < 3; i++) begin
      req_raw();
      chk(out_left == 0 && out_right == 0, "R2 zero before prime", out_left, 0);
    end
    chk(rep_cnt == 0, "R2 no repeat before prime", rep_cnt, 0);
    for (int i = 0; i < 10; i++) begin send_loud(); @(negedge wr_clk); end
    repeat (20) @(negedge rd_clk);
    req_raw();
    chk(out_left == loud(1), "R2 first frame", out_left, loud(1));
    chk(out_right == ~loud(1), "R3 first pair", out_right, ~loud(1));
    prev = 1;

    // underflow: reads outpace writes
    stream_phase(60, 14, 18, 10, 1'b1);
    chk(rep_cnt > 0, "R5 repeats seen", rep_cnt, 1);
    chk(drop_cnt == 0, "R4 no drop below mark", drop_cnt, 0);
    // overflow: writes outpace reads
    lc = low_cnt;
    stream_phase(150, 7, 9, 12, 1'b0);
    chk(drop_cnt > 0, "R4 drops seen", drop_cnt, 1);
    chk(low_cnt == lc, "R9 ready high", low_cnt - lc, 0);
    // recovery, then settle at the low mark
    stream_phase(60, 20, 24, 10, 1'b0);
    for (int i = 0; i < 3; i++) begin send_loud(); @(negedge wr_clk); end
    repeat (12) @(negedge rd_clk);
    for (int i = 0; i < 12; i++) begin repeat (4) @(negedge rd_clk); req_stream(1'b0); end
    chk(prev == wtag - 4, "R5 settles at low mark", prev, wtag - 4);
    chk(sumgap == int'(drop_cnt), "R4 gaps equal drops", sumgap, drop_cnt);

    // R8 clears
    @(negedge wr_clk); clr_drop = 1; clr_recenter = 1;
    @(negedge wr_clk); clr_drop = 0; clr_recenter = 0;
    @(negedge rd_clk); clr_rep = 1;
    @(negedge rd_clk); clr_rep = 0;
    chk(drop_cnt == 0, "R8 drop clear", drop_cnt, 0);
    chk(rep_cnt == 0, "R8 rep clear", rep_cnt, 0);

    // silence episode, FIFO holds exactly four frames prev+1..prev+4
    for (int i = 0; i < 4; i++) begin el[i] = loud(prev + 1 + i); er[i] = ~loud(prev + 1 + i); end
    lc = low_cnt;
    for (k = 1; k <= 7; k++) begin send(24'(k), 24'(-k)); repeat (3) @(negedge wr_clk); end
    chk(recenter_cnt == 0, "R6 seven quiet", recenter_cnt, 0);
    send(24'd16, 24'(-16));  // boundary magnitude still quiet
    repeat (3) @(negedge wr_clk);
    chk(recenter_cnt == 1, "R6 eighth quiet", recenter_cnt, 1);
    for (k = 9; k <= 13; k++) begin send(24'(k), 24'(-k)); repeat (3) @(negedge wr_clk); end
    send(24'd17, 24'd0);     // just above threshold ends silence
    repeat (3) @(negedge wr_clk);
    for (int i = 0; i < 6; i++) begin send_loud(); @(negedge wr_clk); end
    chk(low_cnt - lc == 2, "R7 doubled writes", low_cnt - lc, 2);
    chk(drop_cnt == 0, "R7 discards not counted", drop_cnt, 0);
    for (k = 1; k <= 7; k++) begin el[3 + k] = 24'(k); er[3 + k] = 24'(-k); end
    el[11] = 24'd16; er[11] = 24'(-16);
    el[12] = 24'd9;  er[12] = 24'(-9);
    el[13] = 24'd9;  er[13] = 24'(-9);
    el[14] = 24'd10; er[14] = 24'(-10);
    el[15] = 24'd10; er[15] = 24'(-10);
    el[16] = 24'd11; er[16] = 24'(-11);
    el[17] = 24'd17; er[17] = 24'd0;
    el[18] = loud(wtag - 5); er[18] = ~loud(wtag - 5);
    el[19] = loud(wtag - 4); er[19] = ~loud(wtag - 4);
    repeat (12) @(negedge rd_clk);
    for (int i = 0; i < 20; i++) begin
      repeat (3) @(negedge rd_clk);
      req_raw();
      chk(out_left == el[i] && out_right == er[i], "R7 recentred order", out_left, el[i]);
    end
    chk(rep_cnt == 0, "R5 no repeat above mark", rep_cnt, 0);

    // R6 negative: seven quiet then loud
    lc = low_cnt;
    for (k = 1; k <= 7; k++) begin send(24'(k), 24'(k)); repeat (3) @(negedge wr_clk); end
    send_loud();
    repeat (3) @(negedge wr_clk);
    chk(recenter_cnt == 1, "R6 short run ignored", recenter_cnt, 1);
    chk(low_cnt == lc, "R9 no gap without silence", low_cnt - lc, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule